// File: doc/BRIEF.md
# Clock-Gating Enable Scheduler

This block generates a per-cycle enable for the clock gate of one frequency-scaled domain. A 4-bit schedule code selects a fraction P/N: P enabled cycles in every repeating window of N cycles. The domain behind the gate therefore runs at P/N of the source clock.

The sixteen fractions do not follow a plain divider. The window length changes from code to code (2 to 16 cycles), and the enabled cycles are spread across each window by an accumulator, so that the gaps between enables stay as even as the fraction allows. A strobe marks the first cycle of every window.

The code input is registered into a shadow stage. It becomes active only when the running window ends, so a window never mixes two fractions. The reset input is asserted asynchronously and released through a short synchronizer. After reset the block is idle (code 0) and holds the enable low.

Top module: `clkgate_sched`

## Requirements
- R1: While reset is asserted, and after its release until a non-zero code has been loaded, `gate_en` is 0 and `win_start` is 1.
- R2: Code 0 never asserts `gate_en`, and its window is one cycle long, so `win_start` is 1 on every cycle.
- R3: The window length N and the pulse count P per window are, by code (code: P/N): 1: 1/16, 2: 1/10, 3: 1/7, 4: 1/5, 5: 1/4, 6: 1/3, 7: 1/2, 8: 2/3, 9: 3/4, 10: 4/5, 11: 6/7, 12: 7/8, 13: 9/10, 14: 15/16.
- R4: Code 15 uses a 16-cycle window and asserts `gate_en` on every cycle.
- R5: Within a window, a sum starts at 0 and gains P on each cycle. `gate_en` is 1 on the cycles where the sum reaches N or more, and N is then taken off the sum. As a result, the first enable of a window falls on cycle ceil(N/P)-1, counting from 0. Every gap between consecutive enables, including a gap across a window boundary, is floor(N/P) or ceil(N/P) cycles.
- R6: `win_start` is 1 on exactly the first cycle of each window. The cycle after the last cycle of a window always has `win_start` high.
- R7: A code applied in the middle of a window does not change that window. The window keeps its old length and pulse count, and the new fraction begins with the next window.
- R8: The input code is registered on every rising edge. The active code is replaced only on the edge that ends a window, and it takes the value registered on the edge before. A code that was present only in the middle of a window therefore has no effect. From idle, a code driven before edge k starts its window after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock of the domain |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| sched_code | input | 4 | Requested schedule code (0 idle to 15 full rate) |
| gate_en | output | 1 | Enable for the external clock gate on this cycle |
| win_start | output | 1 | High on the first cycle of each window |

## Verification
The bound checker checks the following on every cycle:
- the window counter stays below the active window length;
- each window carries exactly its P enables;
- code 0 never enables and code 15 always enables;
- the active code changes only where a new window starts;
- every window end is followed by a start strobe.

The bench scenarios cover what the checker cannot see by itself:
- the table values seen at the ports;
- the placement of the first enable and the spacing between enables;
- the two-edge latency from the input to a new window;
- a code that appears only mid-window and is ignored.

// File: rtl/clkgate_sched_pkg.sv
package clkgate_sched_pkg;

  localparam int CODE_W  = 4;
  localparam int MAX_WIN = 16;
  localparam int CNT_W   = $clog2(MAX_WIN);
  localparam int FR_W    = $clog2(MAX_WIN) + 1;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic [FR_W-1:0] pulses;
    logic [FR_W-1:0] win;
  } frac_t;

  // Pulse count and window length selected by each schedule code.
  function automatic frac_t frac_of(code_t c);
    frac_t f;
    unique case (c)
      4'd0:  begin f.pulses = FR_W'(0);  f.win = FR_W'(1);  end
      4'd1:  begin f.pulses = FR_W'(1);  f.win = FR_W'(16); end
      4'd2:  begin f.pulses = FR_W'(1);  f.win = FR_W'(10); end
      4'd3:  begin f.pulses = FR_W'(1);  f.win = FR_W'(7);  end
      4'd4:  begin f.pulses = FR_W'(1);  f.win = FR_W'(5);  end
      4'd5:  begin f.pulses = FR_W'(1);  f.win = FR_W'(4);  end
      4'd6:  begin f.pulses = FR_W'(1);  f.win = FR_W'(3);  end
      4'd7:  begin f.pulses = FR_W'(1);  f.win = FR_W'(2);  end
      4'd8:  begin f.pulses = FR_W'(2);  f.win = FR_W'(3);  end
      4'd9:  begin f.pulses = FR_W'(3);  f.win = FR_W'(4);  end
      4'd10: begin f.pulses = FR_W'(4);  f.win = FR_W'(5);  end
      4'd11: begin f.pulses = FR_W'(6);  f.win = FR_W'(7);  end
      4'd12: begin f.pulses = FR_W'(7);  f.win = FR_W'(8);  end
      4'd13: begin f.pulses = FR_W'(9);  f.win = FR_W'(10); end
      4'd14: begin f.pulses = FR_W'(15); f.win = FR_W'(16); end
      default: begin f.pulses = FR_W'(16); f.win = FR_W'(16); end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/sched_rst_sync.sv
module sched_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sched_code_reg.sv
module sched_code_reg
  import clkgate_sched_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_i,
  input  logic  boundary_i,
  output code_t act_o
);

  code_t shadow_q, shadow_d;
  code_t act_q, act_d;

  always_comb begin
    shadow_d = code_i;
    act_d    = act_q;
    if (boundary_i) act_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= act_d;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/sched_win_cnt.sv
module sched_win_cnt
  import clkgate_sched_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FR_W-1:0] win_len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic            last_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    last_o = ({1'b0, cnt_q} == (win_len_i - FR_W'(1)));
    cnt_d  = last_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sched_accum.sv
module sched_accum
  import clkgate_sched_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FR_W-1:0] pulses_i,
  input  logic [FR_W-1:0] win_i,
  input  logic            restart_i,
  output logic            en_o
);

  logic [FR_W-1:0] acc_q, acc_d;
  logic [FR_W:0]   sum;
  logic [FR_W:0]   rem;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, pulses_i};
    en_o = (sum >= {1'b0, win_i});
    rem  = en_o ? (sum - {1'b0, win_i}) : sum;
    if (restart_i) acc_d = '0;
    else           acc_d = rem[FR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/clkgate_sched.sv
module clkgate_sched
  import clkgate_sched_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sched_code,
  output logic              gate_en,
  output logic              win_start
);

  logic             rst_sync_n;
  code_t            act_code;
  frac_t            frac;
  logic [CNT_W-1:0] win_cnt;
  logic             win_last;

  sched_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sched_code_reg u_code (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .code_i     (sched_code),
    .boundary_i (win_last),
    .act_o      (act_code)
  );

  always_comb frac = frac_of(act_code);

  sched_win_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .win_len_i (frac.win),
    .cnt_o     (win_cnt),
    .last_o    (win_last)
  );

  sched_accum u_acc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pulses_i  (frac.pulses),
    .win_i     (frac.win),
    .restart_i (win_last),
    .en_o      (gate_en)
  );

  assign win_start = (win_cnt == '0);

endmodule

// File: rtl/clkgate_sched_chk.sv
module clkgate_sched_chk
  import clkgate_sched_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input code_t            act_code,
  input logic [CNT_W-1:0] cnt,
  input logic             gate_en,
  input logic             win_start
);

  frac_t           fr;
  logic            at_end;
  logic [FR_W-1:0] seen_q;

  always_comb begin
    fr     = frac_of(act_code);
    at_end = ({1'b0, cnt} == (fr.win - FR_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= at_end ? '0 : seen_q + FR_W'(gate_en);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < fr.win);

  // R3
  window_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |-> ((seen_q + FR_W'(gate_en)) == fr.pulses));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == '0) |-> !gate_en);

  // R4
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == '1) |-> gate_en);

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_code) |-> win_start);

  // R6
  next_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> win_start);

endmodule

bind clkgate_sched clkgate_sched_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .act_code  (act_code),
  .cnt       (win_cnt),
  .gate_en   (gate_en),
  .win_start (win_start)
);

// File: tb/test_clkgate_sched.sv
module test_clkgate_sched;

  logic       clk;
  logic       rst_n;
  logic [3:0] sched_code;
  logic       gate_en;
  logic       win_start;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  clkgate_sched i_clkgate_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .sched_code (sched_code),
    .gate_en    (gate_en),
    .win_start  (win_start)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  function automatic int exp_p(int c);
    case (c)
      0: return 0;   1: return 1;   2: return 1;   3: return 1;
      4: return 1;   5: return 1;   6: return 1;   7: return 1;
      8: return 2;   9: return 3;   10: return 4;  11: return 6;
      12: return 7;  13: return 9;  14: return 15; default: return 16;
    endcase
  endfunction

  function automatic int exp_n(int c);
    case (c)
      0: return 1;   1: return 16;  2: return 10;  3: return 7;
      4: return 5;   5: return 4;   6: return 3;   7: return 2;
      8: return 3;   9: return 4;   10: return 5;  11: return 7;
      12: return 8;  13: return 10; default: return 16;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic align_start();
    int guard = 0;
    while (!win_start && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    check(win_start == 1'b1, "R6 window start seen", int'(win_start), 1);
  endtask

  // Apply a code, let it settle, then measure two full windows.
  task automatic run_code(int c);
    int p = exp_p(c);
    int n = exp_n(c);
    int len [2];
    int pul [2];
    int idx = 0;
    int last = -1;
    int first = -1;
    int bad_gap = 0;
    int gmin = (p > 0) ? n / p : 0;
    int gmax = (p > 0) ? (n + p - 1) / p : 0;
    string tag;
    sched_code = 4'(c);
    repeat (20) @(negedge clk);
    align_start();
    for (int w = 0; w < 2; w++) begin
      len[w] = 0;
      pul[w] = 0;
      do begin
        if (gate_en) begin
          pul[w]++;
          if (last >= 0 && ((idx - last) < gmin || (idx - last) > gmax)) bad_gap++;
          last = idx;
          if (w == 0 && first < 0) first = len[w];
        end
        len[w]++;
        idx++;
        @(negedge clk);
      end while (!win_start && len[w] < 40);
    end
    tag = (c == 0) ? "R2" : (c == 15) ? "R4" : "R3";
    for (int w = 0; w < 2; w++) begin
      check(len[w] == n, {tag, " window length"}, len[w], n);
      check(pul[w] == p, {tag, " pulses per window"}, pul[w], p);
    end
    if (p > 0) begin
      check(first == gmax - 1, "R5 first enable position", first, gmax - 1);
      check(bad_gap == 0, "R5 uneven gap count", bad_gap, 0);
    end
  endtask

  initial begin
    #800us;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    sched_code = 4'd0;
    repeat (3) @(negedge clk);
    // R1 state during reset
    check(gate_en == 1'b0, "R1 gate_en in reset", int'(gate_en), 0);
    check(win_start == 1'b1, "R1 win_start in reset", int'(win_start), 1);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(gate_en == 1'b0 && win_start == 1'b1, "R1 idle after release",
            int'({gate_en, win_start}), 1);
    end

    // R8 latency from idle: driven before edge k, window from edge k+1
    begin
      int first_on = -1;
      sched_code = 4'd4;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (k == 1) check(win_start == 1'b1 && gate_en == 1'b0, "R8 still idle at k",
                          int'({gate_en, win_start}), 1);
        if (k == 3) check(win_start == 1'b0, "R8 new window running", int'(win_start), 0);
        if (gate_en && first_on < 0) first_on = k;
      end
      check(first_on == 6, "R8 first enable cycle", first_on, 6);
    end

    // R2 R3 R4 R5 sweep over every code, then a few descending steps
    for (int c = 0; c < 16; c++) run_code(c);
    run_code(14);
    run_code(3);
    run_code(0);

    // R7 R8 mid-window change and a brief code that must be ignored
    run_code(1);
    begin
      int len = 0;
      int pul = 0;
      int pos = -1;
      do begin
        if (len == 3) sched_code = 4'd15;
        if (len == 6) sched_code = 4'd7;
        if (len == 7) sched_code = 4'd15;
        if (gate_en) begin
          pul++;
          pos = len;
        end
        len++;
        @(negedge clk);
      end while (!win_start && len < 40);
      check(len == 16, "R7 old window length kept", len, 16);
      check(pul == 1, "R7 old pulse count kept", pul, 1);
      check(pos == 15, "R7 old pulse position", pos, 15);
      len = 0;
      pul = 0;
      do begin
        if (gate_en) pul++;
        len++;
        @(negedge clk);
      end while (!win_start && len < 40);
      check(len == 16 && pul == 16, "R8 brief code ignored, new code active",
            pul, 16);
    end

    // R1 reset in operation drops the enable at once
    rst_n = 1'b0;
    #1ns;
    check(gate_en == 1'b0, "R1 asynchronous reset", int'(gate_en), 0);
    sched_code = 4'd0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(gate_en == 1'b0 && win_start == 1'b1, "R1 idle after second reset",
          int'({gate_en, win_start}), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule